// File: doc/BRIEF.md
# Opcode Fetch Substitution Unit

This unit sits on the read path between a memory data bus and the data input of a small 8-bit processor. On every cycle that the processor marks as an opcode fetch, it inspects the byte coming from memory. If that byte belongs to a reserved class of one-byte do-nothing opcodes, the memory byte is blocked. In its place the processor sees a substitute opcode read from a 32-entry remap table. Operand fetches and data reads always pass through untouched.

The reserved class is recognised by a fixed pattern in the low bits of the byte. The remaining high bits select the table entry, so each reserved code can stand for any opcode the processor already understands. The byte that actually came from memory is captured in a register, so a downstream control sequencer can decode the real instruction rather than the alias the processor executes. A small write port lets the table be reprogrammed. Reset restores a default table.

Top module: `ofs_unit`

## Requirements
- R1: A fetched byte is eligible for substitution exactly when its bits [2:0] equal binary 011; bits [7:3] may hold any value, and a byte with any other low pattern is passed unchanged.
- R2: While `fetch` is low, `cpu_data` equals `mem_data` in the same cycle, whatever the byte's value, including bytes whose low bits are 011.
- R3: On a substituted fetch, `cpu_data` equals the table entry whose index is `mem_data[7:3]`, and the memory byte does not appear on `cpu_data`.
- R4: After reset the table holds ADh at index 26 (so a fetched D3h becomes ADh) and EAh at every other index.
- R5: `true_op` takes the value of `mem_data` at each rising clock edge where `fetch` is high, and it never takes the substitute value. Reset clears it to 00h.
- R6: `true_op` holds its value across all clock edges where `fetch` is low.
- R7: `subst_active` is high in exactly those cycles where `fetch` is high and the R1 pattern matches. It is combinational and low in every other cycle, including during reset.
- R8: When `tbl_we` is high at a rising edge, `tbl_wdata` is written to entry `tbl_addr`. A fetch in that same cycle still sees the old entry, and fetches from the next cycle on see the new one.
- R9: Asserting `rst_n` low takes effect without waiting for a clock edge and restores the R4 table over any programmed contents. Release of reset is synchronised to the clock over two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch | input | 1 | High during an opcode-fetch cycle |
| mem_data | input | 8 | Byte read from memory |
| tbl_we | input | 1 | Remap table write enable |
| tbl_addr | input | 5 | Remap table write index |
| tbl_wdata | input | 8 | Remap table write data |
| cpu_data | output | 8 | Byte presented to the processor |
| subst_active | output | 1 | High while a substitution is taking place |
| true_op | output | 8 | Last opcode fetched from memory, as it was in memory |

## Verification
The bench builds the unit with its default parameters: an 8-bit opcode, a 3-bit match field with the value 011, and therefore a 32-entry table. At this size every reserved opcode can be swept one by one against the known reset contents. Every non-matching low-bit pattern is also checked alongside a matching index. Writes to the table and a fetch in the same cycle, and an asynchronous reset in the middle of a cycle after programming, are both exercised. So are stretches of operand cycles that carry matching bytes while the captured opcode must stay still.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  // Default geometry and reset contents of the remap unit.
  localparam int unsigned DEF_OP_W   = 8;
  localparam int unsigned DEF_TAG_W  = 3;
  localparam logic [DEF_TAG_W-1:0] DEF_TAG_VAL = 3'b011;
  localparam logic [DEF_OP_W-1:0]  DEF_FILL_OP = 8'hEA;
  localparam int unsigned DEF_SPECIAL_IDX = 26;
  localparam logic [DEF_OP_W-1:0]  DEF_SPECIAL_OP = 8'hAD;
endpackage

// File: rtl/ofs_rst_sync.sv
module ofs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/ofs_match.sv
module ofs_match #(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned TAG_W = 3,
  parameter logic [TAG_W-1:0] TAG_VAL = 3'b011,
  localparam int unsigned IDX_W = OP_W - TAG_W
) (
  input  logic            fetch,
  input  logic [OP_W-1:0] op,
  output logic            hit,
  output logic [IDX_W-1:0] idx
);
  logic tag_eq;

  always_comb begin
    tag_eq = (op[TAG_W-1:0] == TAG_VAL);
    hit    = fetch & tag_eq;
    idx    = op[OP_W-1:TAG_W];
  end
endmodule

// File: rtl/ofs_remap_table.sv
module ofs_remap_table #(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned SPECIAL_IDX = 26,
  parameter logic [OP_W-1:0] SPECIAL_OP = 8'hAD,
  parameter logic [OP_W-1:0] FILL_OP = 8'hEA,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [OP_W-1:0]  wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [OP_W-1:0]  rdata
);
  logic [OP_W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    localparam logic [OP_W-1:0] RST_VAL = (g == SPECIAL_IDX) ? SPECIAL_OP : FILL_OP;
    logic            ent_en;
    logic [OP_W-1:0] ent_d;

    always_comb begin
      ent_en = we && (waddr == IDX_W'(g));
      ent_d  = ent_en ? wdata : ent_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= RST_VAL;
      else        ent_q[g] <= ent_d;
    end
  end

  assign rdata = ent_q[raddr];
endmodule

// File: rtl/ofs_true_latch.sv
module ofs_true_latch #(
  parameter int unsigned OP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [OP_W-1:0] d,
  output logic [OP_W-1:0] q
);
  logic [OP_W-1:0] q_r;
  logic [OP_W-1:0] q_nx;

  always_comb begin
    q_nx = en ? d : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nx;
  end

  assign q = q_r;
endmodule

// File: rtl/ofs_unit.sv
module ofs_unit
  import ofs_pkg::*;
#(
  parameter int unsigned OP_W  = DEF_OP_W,
  parameter int unsigned TAG_W = DEF_TAG_W,
  parameter logic [TAG_W-1:0] TAG_VAL = DEF_TAG_VAL,
  parameter int unsigned SPECIAL_IDX = DEF_SPECIAL_IDX,
  parameter logic [OP_W-1:0] SPECIAL_OP = DEF_SPECIAL_OP,
  parameter logic [OP_W-1:0] FILL_OP = DEF_FILL_OP,
  localparam int unsigned IDX_W = OP_W - TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch,
  input  logic [OP_W-1:0]  mem_data,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [OP_W-1:0]  tbl_wdata,
  output logic [OP_W-1:0]  cpu_data,
  output logic             subst_active,
  output logic [OP_W-1:0]  true_op
);
  logic             srst_n;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [OP_W-1:0]  alias_op;

  ofs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n)
  );

  ofs_match #(.OP_W(OP_W), .TAG_W(TAG_W), .TAG_VAL(TAG_VAL)) u_match (
    .fetch(fetch), .op(mem_data), .hit(hit), .idx(idx)
  );

  ofs_remap_table #(
    .OP_W(OP_W), .IDX_W(IDX_W), .SPECIAL_IDX(SPECIAL_IDX),
    .SPECIAL_OP(SPECIAL_OP), .FILL_OP(FILL_OP)
  ) u_tbl (
    .clk(clk), .rst_n(srst_n), .we(tbl_we), .waddr(tbl_addr),
    .wdata(tbl_wdata), .raddr(idx), .rdata(alias_op)
  );

  ofs_true_latch #(.OP_W(OP_W)) u_true (
    .clk(clk), .rst_n(srst_n), .en(fetch), .d(mem_data), .q(true_op)
  );

  // Memory byte is isolated from the processor whenever an alias is driven.
  always_comb begin
    cpu_data     = hit ? alias_op : mem_data;
    subst_active = hit && srst_n;
  end
endmodule

// File: rtl/ofs_unit_chk.sv
module ofs_unit_chk #(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned TAG_W = 3,
  parameter logic [TAG_W-1:0] TAG_VAL = 3'b011,
  localparam int unsigned IDX_W = OP_W - TAG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch,
  input logic [OP_W-1:0]  mem_data,
  input logic             tbl_we,
  input logic [IDX_W-1:0] tbl_addr,
  input logic [OP_W-1:0]  tbl_wdata,
  input logic [OP_W-1:0]  cpu_data,
  input logic             subst_active,
  input logic [OP_W-1:0]  true_op
);
  // R2: operand and data cycles are transparent
  a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch |-> (cpu_data == mem_data));

  // R1: non-matching fetches are transparent and not flagged
  a_r1_nomatch: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && mem_data[TAG_W-1:0] != TAG_VAL) |-> (cpu_data == mem_data && !subst_active));

  // R7: flag only on fetch cycles
  a_r7_flag_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    subst_active |-> fetch);

  // R5: captured opcode is the memory byte
  a_r5_true_op: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> (true_op == $past(mem_data)));

  // R6: captured opcode holds between fetches
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch |=> $stable(true_op));

  // R8: a written entry is seen by the next matching fetch of its index
  a_r8_write: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> ((fetch && mem_data[TAG_W-1:0] == TAG_VAL
                 && mem_data[OP_W-1:TAG_W] == $past(tbl_addr))
                -> (cpu_data == $past(tbl_wdata))));
endmodule

bind ofs_unit ofs_unit_chk #(.OP_W(OP_W), .TAG_W(TAG_W), .TAG_VAL(TAG_VAL)) u_chk (
  .clk(clk), .rst_n(srst_n), .fetch(fetch), .mem_data(mem_data),
  .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
  .cpu_data(cpu_data), .subst_active(subst_active), .true_op(true_op)
);

// File: tb/ofs_unit_tb.sv
module ofs_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fetch;
  logic [7:0] mem_data;
  logic       tbl_we;
  logic [4:0] tbl_addr;
  logic [7:0] tbl_wdata;
  logic [7:0] cpu_data;
  logic       subst_active;
  logic [7:0] true_op;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ofs_unit u_dut (
    .clk(clk), .rst_n(rst_n), .fetch(fetch), .mem_data(mem_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .cpu_data(cpu_data), .subst_active(subst_active), .true_op(true_op)
  );

  function automatic logic [7:0] dflt(input int i);
    return (i == 26) ? 8'hAD : 8'hEA;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, settle, leave sampling to the caller.
  task automatic drive(input logic f, input logic [7:0] d);
    @(negedge clk);
    fetch = f; mem_data = d;
    #2;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fetch = 1'b0; mem_data = 8'hD3;
    tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R5 reset true_op", true_op, 8'h00);
    chk("R7 reset flag", {7'b0, subst_active}, 8'h00);
    chk("R2 reset passthru", cpu_data, 8'hD3);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_default_sweep();
    for (int i = 0; i < 32; i++) begin
      logic [7:0] op;
      op = {i[4:0], 3'b011};
      drive(1'b1, op);
      chk($sformatf("R3 R4 alias op=%02h", op), cpu_data, dflt(i));
      chk("R7 flag on match", {7'b0, subst_active}, 8'h01);
      after_edge();
      chk("R5 true_op not alias", true_op, op);
    end
    drive(1'b1, 8'hD3);
    chk("R4 D3 to AD", cpu_data, 8'hAD);
    drive(1'b0, 8'h00);
  endtask

  task automatic t_nomatch();
    for (int l = 0; l < 8; l++) begin
      logic [7:0] op;
      if (l == 3) continue;
      op = {5'b11010, l[2:0]};
      drive(1'b1, op);
      chk("R1 low bits differ", cpu_data, op);
      chk("R7 no flag", {7'b0, subst_active}, 8'h00);
    end
    drive(1'b0, 8'h00);
  endtask

  task automatic t_operand();
    drive(1'b1, 8'hA9);
    after_edge();
    drive(1'b0, 8'hD3);
    chk("R2 operand match byte", cpu_data, 8'hD3);
    chk("R7 no flag operand", {7'b0, subst_active}, 8'h00);
    after_edge();
    chk("R6 true_op after operand", true_op, 8'hA9);
  endtask

  task automatic t_hold();
    drive(1'b1, 8'h4B);
    after_edge();
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 8'h13 + 8'(k * 8));
      chk("R2 data byte", cpu_data, 8'h13 + 8'(k * 8));
      after_edge();
      chk("R6 hold", true_op, 8'h4B);
    end
  endtask

  task automatic t_write();
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 5'd26; tbl_wdata = 8'h4C;
    fetch = 1'b1; mem_data = 8'hD3;
    #2;
    chk("R8 same-cycle old entry", cpu_data, 8'hAD);
    @(negedge clk);
    tbl_addr = 5'd0; tbl_wdata = 8'h55;
    fetch = 1'b1; mem_data = 8'hD3;
    #2;
    chk("R8 new entry 26", cpu_data, 8'h4C);
    @(negedge clk);
    tbl_we = 1'b0;
    fetch = 1'b1; mem_data = 8'h03;
    #2;
    chk("R8 new entry 0", cpu_data, 8'h55);
    drive(1'b1, 8'h0B);
    chk("R8 neighbour untouched", cpu_data, 8'hEA);
    drive(1'b0, 8'h00);
  endtask

  task automatic t_reset_restore();
    drive(1'b1, 8'hD3);
    chk("R8 programmed before reset", cpu_data, 8'h4C);
    #1;
    rst_n = 1'b0;
    #1;
    chk("R9 async table restore", cpu_data, 8'hAD);
    chk("R9 async true_op clear", true_op, 8'h00);
    chk("R7 no flag in reset", {7'b0, subst_active}, 8'h00);
    @(negedge clk);
    fetch = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1'b1, 8'h03);
    chk("R9 entry 0 restored", cpu_data, 8'hEA);
    drive(1'b0, 8'h00);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_default_sweep();
    t_nomatch();
    t_operand();
    t_hold();
    t_write();
    t_reset_restore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule